// File: doc/BRIEF.md
# Parallel Bus Slave Cycle Controller

This block is the slave side of a 32-bit asynchronous parallel backplane bus. It handles single read and write cycles. A master places an address, a 6-bit address-space tag, a size flag and a direction flag on the bus. It then lowers the address strobe and one or both data strobes. The controller brings every strobe and control line into its local clock domain through a two-flop synchronizer. It waits until the address and tag have held still for one extra clock. It then decides from the tag how many address bits to compare against a base window.

When the cycle is addressed to it, the controller works out the byte lanes from the two data strobes, the size flag and address bit 1. It then takes one of three actions: it stores the selected lanes into a small register array, it drives them out from that array, or it refuses the cycle. A refusal ends the cycle with a bus-error answer, or with a retry answer while the local busy input is high. Interrupt-acknowledge cycles, unknown tags and addresses outside the window get no answer of any kind.

Top module: `pbus_slave`

## Requirements
- R1: While reset is asserted, and after reset is released, the acknowledge, error and retry outputs are high (negated) and the data output enable is low, until a cycle is addressed to the slave.
- R2: Only the tags 0x29 and 0x2D (16-bit space), 0x39 and 0x3D (24-bit space) and 0x09 and 0x0D (32-bit space) can select the slave. Every other tag, including the lock codes 0x2C and 0x05 and reserved codes such as 0x33, gives no answer and leaves the array unchanged.
- R3: The slave compares byte-address bits [15:5] with `win_base` in the 16-bit space, bits [23:5] in the 24-bit space and bits [31:5] in the 32-bit space. Bits above the selected space are ignored. A mismatch gives no answer.
- R4: While `bus_intack_n` is low, the slave gives no answer and does not write, whatever the tag.
- R5: The active-low strobe pair `bus_dstb_n[1:0]` selects the lanes, with lane k being data bits [8k+7:8k] and A = address bit 1. Strobe 0 alone selects lane 2A, and strobe 1 alone selects lane 2A+1; both of these require `bus_long_n` high. Both strobes with `bus_long_n` high select lanes 2A and 2A+1. Both strobes with `bus_long_n` low select all four lanes and require A = 0. Every other combination is answered with a bus error and writes nothing.
- R6: On a write (`bus_wr_n` low), the selected lanes of word `address[4:2]` take the bus data and the other lanes keep their value. The acknowledge falls only after the data has been stored.
- R7: On a read, `bus_dout` carries the stored word with the unselected lanes forced to zero. `bus_dout_en` rises at least one clock before the acknowledge falls, and it is high only on reads.
- R8: While `busy` is high when the strobes are decoded, an addressed, well-formed cycle is answered with retry instead of acknowledge, and it does not write.
- R9: At most one answer is asserted at a time. An answer stays asserted while either data strobe is low, and it is released once both strobes have been seen high through the synchronizer.
- R10: While the address strobe is low, the slave does not decode until the address and tag have been equal on two consecutive clocks. A write then goes to the settled address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_base | input | 32 | Base of the slave's address window (bits [31:5] used) |
| busy | input | 1 | Local busy flag; answer with retry while high |
| bus_astb_n | input | 1 | Address strobe, active low |
| bus_dstb_n | input | 2 | Data strobes, active low |
| bus_long_n | input | 1 | Long-word size flag, active low |
| bus_wr_n | input | 1 | Direction: low for write, high for read |
| bus_intack_n | input | 1 | Interrupt-acknowledge cycle flag, active low |
| bus_amod | input | 6 | Address-space tag |
| bus_addr | input | 31 | Address bits [31:1] |
| bus_din | input | 32 | Write data from the bus |
| bus_dout | output | 32 | Read data to the bus |
| bus_dout_en | output | 1 | Read data driver enable |
| bus_ack_n | output | 1 | Transfer acknowledge, active low |
| bus_err_n | output | 1 | Bus error answer, active low |
| bus_rty_n | output | 1 | Retry answer, active low |

## Verification
A decoder that picks the wrong address space or lets through a foreign tag shows up at once. The master waits out its time limit with no answer, or an answer appears where none should. A faulty lane decoder or array write enable shows up only one cycle later, when a read of the same word returns the wrong bytes. The bench therefore follows every questionable write with a read-back. A state machine that drops its answer early, or raises it before data is stored or driven, is visible within one clock. It is caught by comparing the answer outputs against the strobe release and against the output enable on the previous clock.

// File: rtl/pbus_slave_pkg.sv
package pbus_slave_pkg;

  typedef enum logic [1:0] {
    SP_NONE = 2'd0,
    SP_S16  = 2'd1,
    SP_S24  = 2'd2,
    SP_S32  = 2'd3
  } space_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_QUAL   = 3'd1,
    ST_DSWAIT = 3'd2,
    ST_READ   = 3'd3,
    ST_HOLD   = 3'd4,
    ST_SKIP   = 3'd5
  } state_e;

  // Tag to address space; only plain data/supervisor codes are accepted.
  function automatic space_e tag_space(input logic [5:0] tag);
    space_e sp;
    case (tag)
      6'h29, 6'h2D: sp = SP_S16;
      6'h39, 6'h3D: sp = SP_S24;
      6'h09, 6'h0D: sp = SP_S32;
      default:      sp = SP_NONE;
    endcase
    return sp;
  endfunction

endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/pbus_decode.sv
module pbus_decode
  import pbus_slave_pkg::*;
#(
  parameter int AW  = 32,
  parameter int LSB = 5
) (
  input  logic [5:0]    tag,
  input  logic [AW-1:1] addr,
  input  logic [AW-1:0] base,
  output logic          hit
);

  localparam int NSP = 3;
  localparam int SPW [NSP] = '{16, 24, 32};
  localparam logic [AW-1:0] HI_MASK = {AW{1'b1}} << LSB;

  logic [AW-1:0]  full_addr;
  logic [AW-1:0]  diff;
  logic [NSP-1:0] match;
  space_e         space;

  assign full_addr = {addr, 1'b0};
  assign diff      = full_addr ^ base;
  assign space     = tag_space(tag);

  for (genvar g = 0; g < NSP; g++) begin : g_space
    localparam logic [AW-1:0] MASK = HI_MASK & ~({AW{1'b1}} << SPW[g]);
    assign match[g] = ((diff & MASK) == '0);
  end

  always_comb begin
    case (space)
      SP_S16:  hit = match[0];
      SP_S24:  hit = match[1];
      SP_S32:  hit = match[2];
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/pbus_lanes.sv
module pbus_lanes (
  input  logic [1:0] dstb_n,
  input  logic       long_n,
  input  logic       a01,
  output logic [3:0] lane_en,
  output logic       bad
);

  always_comb begin
    lane_en = 4'b0000;
    bad     = 1'b0;
    case (dstb_n)
      2'b00: begin
        if (long_n)    lane_en = a01 ? 4'b1100 : 4'b0011;
        else if (!a01) lane_en = 4'b1111;
        else           bad     = 1'b1;
      end
      2'b10: begin
        if (long_n) lane_en = a01 ? 4'b0100 : 4'b0001;
        else        bad     = 1'b1;
      end
      2'b01: begin
        if (long_n) lane_en = a01 ? 4'b1000 : 4'b0010;
        else        bad     = 1'b1;
      end
      default: begin
        lane_en = 4'b0000;
        bad     = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/pbus_regfile.sv
module pbus_regfile #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  localparam int NB    = DW / 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [NB-1:0]    be,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);

  logic [DEPTH-1:0][DW-1:0] words;

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    for (genvar b = 0; b < NB; b++) begin : g_byte
      logic [7:0] byte_q;
      logic       byte_en;
      assign byte_en = we && (idx == IDX_W'(w)) && be[b];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       byte_q <= 8'h00;
        else if (byte_en) byte_q <= wdata[8*b +: 8];
      end
      assign words[w][8*b +: 8] = byte_q;
    end
  end

  assign rdata = words[idx];

endmodule

// File: rtl/pbus_slave.sv
module pbus_slave
  import pbus_slave_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int DEPTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] win_base,
  input  logic              busy,
  input  logic              bus_astb_n,
  input  logic [1:0]        bus_dstb_n,
  input  logic              bus_long_n,
  input  logic              bus_wr_n,
  input  logic              bus_intack_n,
  input  logic [5:0]        bus_amod,
  input  logic [ADDR_W-1:1] bus_addr,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_dout_en,
  output logic              bus_ack_n,
  output logic              bus_err_n,
  output logic              bus_rty_n
);

  localparam int NB       = DATA_W / 8;
  localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int BYTE_LSB = $clog2(NB);
  localparam int WIN_LSB  = BYTE_LSB + IDX_W;
  localparam int CTL_W    = 6;

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_q, rst_q, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end
  assign rst_i = rst_q;

  // Synchronized bus controls {intack, wr, long, dstb[1:0], astb}.
  logic [CTL_W-1:0] ctl_raw, ctl_s;
  logic             astb_s, long_s, wr_s, intack_s;
  logic [1:0]       ds_s;

  assign ctl_raw = {bus_intack_n, bus_wr_n, bus_long_n, bus_dstb_n, bus_astb_n};

  pbus_sync #(
    .W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL({CTL_W{1'b1}})
  ) u_sync (
    .clk(clk), .rst_n(rst_i), .d(ctl_raw), .q(ctl_s)
  );

  assign astb_s   = ctl_s[0];
  assign ds_s     = ctl_s[2:1];
  assign long_s   = ctl_s[3];
  assign wr_s     = ctl_s[4];
  assign intack_s = ctl_s[5];

  // State and held address phase.
  state_e            state_q, state_d;
  logic [ADDR_W-1:1] hold_addr_q;
  logic [5:0]        hold_tag_q;
  logic              hold_ld;
  logic              ack_q, ack_d, err_q, err_d, rty_q, rty_d;
  logic              doe_q, doe_d;
  logic [DATA_W-1:0] dout_q, dout_d;
  logic              dout_ld;
  logic              wr_en;

  logic              addr_stable, hit;
  logic [NB-1:0]     lane_en;
  logic              lane_bad;
  logic [DATA_W-1:0] rd_word, rd_masked;

  assign addr_stable = (bus_addr == hold_addr_q) && (bus_amod == hold_tag_q);

  pbus_decode #(.AW(ADDR_W), .LSB(WIN_LSB)) u_decode (
    .tag(hold_tag_q), .addr(hold_addr_q), .base(win_base), .hit(hit)
  );

  pbus_lanes u_lanes (
    .dstb_n(ds_s), .long_n(long_s), .a01(hold_addr_q[1]),
    .lane_en(lane_en), .bad(lane_bad)
  );

  pbus_regfile #(.DEPTH(DEPTH), .DW(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_i), .we(wr_en),
    .idx(hold_addr_q[WIN_LSB-1:BYTE_LSB]), .be(lane_en),
    .wdata(bus_din), .rdata(rd_word)
  );

  for (genvar k = 0; k < NB; k++) begin : g_rmask
    assign rd_masked[8*k +: 8] = lane_en[k] ? rd_word[8*k +: 8] : 8'h00;
  end

  // Next-state logic.
  always_comb begin
    state_d = state_q;
    hold_ld = 1'b0;
    ack_d   = ack_q;
    err_d   = err_q;
    rty_d   = rty_q;
    doe_d   = doe_q;
    dout_ld = 1'b0;
    dout_d  = dout_q;
    wr_en   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (!astb_s) begin
          hold_ld = 1'b1;
          state_d = ST_QUAL;
        end
      end
      ST_QUAL: begin
        if (astb_s)                state_d = ST_IDLE;
        else if (!addr_stable)     hold_ld = 1'b1;
        else if (hit && intack_s)  state_d = ST_DSWAIT;
        else                       state_d = ST_SKIP;
      end
      ST_DSWAIT: begin
        if (astb_s) begin
          state_d = ST_IDLE;
        end else if (ds_s != 2'b11) begin
          if (lane_bad) begin
            err_d   = 1'b1;
            state_d = ST_HOLD;
          end else if (busy) begin
            rty_d   = 1'b1;
            state_d = ST_HOLD;
          end else if (!wr_s) begin
            wr_en   = 1'b1;
            ack_d   = 1'b1;
            state_d = ST_HOLD;
          end else begin
            doe_d   = 1'b1;
            dout_ld = 1'b1;
            dout_d  = rd_masked;
            state_d = ST_READ;
          end
        end
      end
      ST_READ: begin
        ack_d   = 1'b1;
        state_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (ds_s == 2'b11) begin
          ack_d   = 1'b0;
          err_d   = 1'b0;
          rty_d   = 1'b0;
          doe_d   = 1'b0;
          state_d = ST_SKIP;
        end
      end
      ST_SKIP: begin
        if (astb_s) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= ST_IDLE;
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
      rty_q   <= 1'b0;
      doe_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
      err_q   <= err_d;
      rty_q   <= rty_d;
      doe_q   <= doe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      hold_addr_q <= '0;
      hold_tag_q  <= '0;
    end else if (hold_ld) begin
      hold_addr_q <= bus_addr;
      hold_tag_q  <= bus_amod;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)       dout_q <= '0;
    else if (dout_ld) dout_q <= dout_d;
  end

  assign bus_dout    = dout_q;
  assign bus_dout_en = doe_q;
  assign bus_ack_n   = ~ack_q;
  assign bus_err_n   = ~err_q;
  assign bus_rty_n   = ~rty_q;

endmodule

// File: rtl/pbus_slave_chk.sv
module pbus_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       bus_wr_n,
  input logic       bus_intack_n,
  input logic       bus_dout_en,
  input logic       bus_ack_n,
  input logic       bus_err_n,
  input logic       bus_rty_n,
  input logic [1:0] ds_s,
  input logic       wr_en
);

  // R9: never more than one answer at once.
  p_single_answer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~bus_ack_n, ~bus_err_n, ~bus_rty_n}) <= 1);

  // R9: an answer is released only after both strobes were seen high.
  p_release_after_strobes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_ack_n) || $rose(bus_err_n) || $rose(bus_rty_n)) |-> ($past(ds_s) == 2'b11));

  // R7: read data is driven at least one clock before the acknowledge.
  p_read_data_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_ack_n) && bus_wr_n) |-> $past(bus_dout_en));

  // R7: the data driver is only on during reads.
  p_drive_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dout_en |-> bus_wr_n);

  // R6: a write acknowledge follows the array store.
  p_write_stored_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_ack_n) && !bus_wr_n) |-> $past(wr_en));

  // R4: no answer during an interrupt-acknowledge cycle.
  p_no_answer_intack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ack_n || !bus_err_n || !bus_rty_n) |-> bus_intack_n);

  // R8: retry only appears when busy was set.
  p_retry_from_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_rty_n) |-> $past(busy));

endmodule

bind pbus_slave pbus_slave_chk u_pbus_slave_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .bus_wr_n     (bus_wr_n),
  .bus_intack_n (bus_intack_n),
  .bus_dout_en  (bus_dout_en),
  .bus_ack_n    (bus_ack_n),
  .bus_err_n    (bus_err_n),
  .bus_rty_n    (bus_rty_n),
  .ds_s         (ds_s),
  .wr_en        (wr_en)
);

// File: tb/pbus_slave_bench.sv
module pbus_slave_bench;

  typedef struct packed {
    logic [5:0]  tag;
    logic [31:0] addr;
    logic        intack_n;
    logic        wr;
    logic [1:0]  ds_n;
    logic        long_n;
    logic [31:0] wd;
    logic        bsy;
    logic [1:0]  rsp;   // 0 none, 1 ack, 2 error, 3 retry
    logic [31:0] rd;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VT [NV] = '{
    '{6'h09, 32'h12345600, 1'b1, 1'b1, 2'b00, 1'b0, 32'hA1B2C3D4, 1'b0, 2'd1, 32'h0},         // R6 long write
    '{6'h0D, 32'h12345600, 1'b1, 1'b0, 2'b00, 1'b0, 32'h0,        1'b0, 2'd1, 32'hA1B2C3D4}, // R7 long read
    '{6'h39, 32'h00345604, 1'b1, 1'b1, 2'b00, 1'b1, 32'h1111BEEF, 1'b0, 2'd1, 32'h0},         // R5 low half
    '{6'h3D, 32'h00345606, 1'b1, 1'b1, 2'b00, 1'b1, 32'hCAFE0000, 1'b0, 2'd1, 32'h0},         // R5 high half
    '{6'h29, 32'hFFFF5604, 1'b1, 1'b0, 2'b00, 1'b0, 32'h0,        1'b0, 2'd1, 32'hCAFEBEEF}, // R3 16-bit space
    '{6'h2D, 32'h00005608, 1'b1, 1'b1, 2'b10, 1'b1, 32'h0000005A, 1'b0, 2'd1, 32'h0},         // R5 lane 0
    '{6'h2D, 32'h0000560A, 1'b1, 1'b1, 2'b01, 1'b1, 32'h77000000, 1'b0, 2'd1, 32'h0},         // R5 lane 3
    '{6'h2D, 32'h00005608, 1'b1, 1'b0, 2'b00, 1'b0, 32'h0,        1'b0, 2'd1, 32'h7700005A}, // R6 merge
    '{6'h2D, 32'h0000560A, 1'b1, 1'b0, 2'b01, 1'b1, 32'h0,        1'b0, 2'd1, 32'h77000000}, // R5 byte read
    '{6'h2D, 32'h00005608, 1'b1, 1'b0, 2'b00, 1'b1, 32'h0,        1'b0, 2'd1, 32'h0000005A}, // R5 word read
    '{6'h2C, 32'h00005608, 1'b1, 1'b1, 2'b00, 1'b0, 32'hFFFFFFFF, 1'b0, 2'd0, 32'h0},         // R2 lock code
    '{6'h33, 32'h00345608, 1'b1, 1'b1, 2'b00, 1'b0, 32'hFFFFFFFF, 1'b0, 2'd0, 32'h0},         // R2 reserved
    '{6'h05, 32'h12345608, 1'b1, 1'b1, 2'b00, 1'b0, 32'hFFFFFFFF, 1'b0, 2'd0, 32'h0},         // R2 lock code
    '{6'h39, 32'h00345708, 1'b1, 1'b1, 2'b00, 1'b0, 32'hFFFFFFFF, 1'b0, 2'd0, 32'h0},         // R3 miss
    '{6'h09, 32'h92345608, 1'b1, 1'b1, 2'b00, 1'b0, 32'hFFFFFFFF, 1'b0, 2'd0, 32'h0},         // R3 top bit miss
    '{6'h0D, 32'h12345608, 1'b0, 1'b1, 2'b00, 1'b0, 32'hFFFFFFFF, 1'b0, 2'd0, 32'h0},         // R4 intack
    '{6'h0D, 32'h12345608, 1'b1, 1'b0, 2'b00, 1'b0, 32'h0,        1'b0, 2'd1, 32'h7700005A}, // R2 R3 R4 untouched
    '{6'h39, 32'hFF345600, 1'b1, 1'b0, 2'b00, 1'b0, 32'h0,        1'b0, 2'd1, 32'hA1B2C3D4}, // R3 24-bit space
    '{6'h0D, 32'h12345602, 1'b1, 1'b1, 2'b00, 1'b0, 32'hDEADDEAD, 1'b0, 2'd2, 32'h0},         // R5 long odd half
    '{6'h0D, 32'h12345600, 1'b1, 1'b1, 2'b10, 1'b0, 32'hDEADDEAD, 1'b0, 2'd2, 32'h0},         // R5 byte with long
    '{6'h0D, 32'h12345600, 1'b1, 1'b0, 2'b00, 1'b0, 32'h0,        1'b0, 2'd1, 32'hA1B2C3D4}, // R5 error wrote nothing
    '{6'h09, 32'h1234560C, 1'b1, 1'b1, 2'b00, 1'b0, 32'hFFFFFFFF, 1'b1, 2'd3, 32'h0},         // R8 retry
    '{6'h09, 32'h1234560C, 1'b1, 1'b0, 2'b00, 1'b0, 32'h0,        1'b0, 2'd1, 32'h00000000}, // R8 no write
    '{6'h09, 32'h1234561C, 1'b1, 1'b1, 2'b00, 1'b0, 32'h0F0F0F0F, 1'b0, 2'd1, 32'h0},         // R6 last word
    '{6'h0D, 32'h1234561C, 1'b1, 1'b0, 2'b00, 1'b1, 32'h0,        1'b0, 2'd1, 32'h00000F0F}  // R5 word read
  };

  logic        clk;
  logic        rst_n;
  logic [31:0] win_base;
  logic        busy;
  logic        bus_astb_n;
  logic [1:0]  bus_dstb_n;
  logic        bus_long_n;
  logic        bus_wr_n;
  logic        bus_intack_n;
  logic [5:0]  bus_amod;
  logic [31:1] bus_addr;
  logic [31:0] bus_din;
  logic [31:0] bus_dout;
  logic        bus_dout_en;
  logic        bus_ack_n;
  logic        bus_err_n;
  logic        bus_rty_n;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  pbus_slave u_pbus_slave (
    .clk(clk), .rst_n(rst_n), .win_base(win_base), .busy(busy),
    .bus_astb_n(bus_astb_n), .bus_dstb_n(bus_dstb_n), .bus_long_n(bus_long_n),
    .bus_wr_n(bus_wr_n), .bus_intack_n(bus_intack_n), .bus_amod(bus_amod),
    .bus_addr(bus_addr), .bus_din(bus_din), .bus_dout(bus_dout),
    .bus_dout_en(bus_dout_en), .bus_ack_n(bus_ack_n), .bus_err_n(bus_err_n),
    .bus_rty_n(bus_rty_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog R9: act=%0d exp=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: act=%08h exp=%08h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] answer();
    if (!bus_ack_n)      return 2'd1;
    else if (!bus_err_n) return 2'd2;
    else if (!bus_rty_n) return 2'd3;
    return 2'd0;
  endfunction

  // Waits for an answer after the strobes are low, checks it, then ends the cycle.
  task automatic finish_cycle(input logic [1:0] rsp, input logic wr, input logic [31:0] rd, input string req);
    logic [1:0] got = 2'd0;
    for (int i = 0; i < 16 && got == 2'd0; i++) begin
      @(negedge clk);
      got = answer();
    end
    chk(got == rsp, req, 32'(got), 32'(rsp));
    if (got == 2'd1 && !wr) begin
      chk(bus_dout_en && bus_dout == rd, req, bus_dout, rd);
    end
    if (got != 2'd0) begin
      repeat (4) @(negedge clk);
      chk(answer() == got, "R9 hold", 32'(answer()), 32'(got));
    end
    bus_dstb_n = 2'b11;
    for (int i = 0; i < 8 && answer() != 2'd0; i++) @(negedge clk);
    chk(answer() == 2'd0 && !bus_dout_en, "R9 release", 32'(answer()), 32'd0);
    bus_astb_n = 1'b1;
    repeat (4) @(negedge clk);
    busy = 1'b0;
  endtask

  task automatic run_cycle(input vec_t v, input string req);
    @(negedge clk);
    bus_amod     = v.tag;
    bus_addr     = v.addr[31:1];
    bus_intack_n = v.intack_n;
    bus_wr_n     = ~v.wr;
    bus_long_n   = v.long_n;
    bus_din      = v.wd;
    busy         = v.bsy;
    @(negedge clk);
    bus_astb_n = 1'b0;
    repeat (2) @(negedge clk);
    bus_dstb_n = v.ds_n;
    finish_cycle(v.rsp, v.wr, v.rd, req);
    bus_intack_n = 1'b1;
  endtask

  initial begin
    rst_n        = 1'b0;
    win_base     = 32'h12345600;
    busy         = 1'b0;
    bus_astb_n   = 1'b1;
    bus_dstb_n   = 2'b11;
    bus_long_n   = 1'b1;
    bus_wr_n     = 1'b1;
    bus_intack_n = 1'b1;
    bus_amod     = 6'h00;
    bus_addr     = '0;
    bus_din      = '0;
    repeat (3) @(negedge clk);
    // R1: outputs released during reset
    chk(answer() == 2'd0 && !bus_dout_en, "R1 in reset", 32'(answer()), 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(answer() == 2'd0 && !bus_dout_en, "R1 after reset", 32'(answer()), 32'd0);

    for (int k = 0; k < NV; k++) begin
      run_cycle(VT[k], $sformatf("vector %0d (R2..R8)", k));
    end

    // R10: address toggles while the strobe is low, then settles on word 5.
    @(negedge clk);
    bus_amod   = 6'h09;
    bus_wr_n   = 1'b0;
    bus_long_n = 1'b0;
    bus_din    = 32'h55AA55AA;
    bus_addr   = 31'(32'h12345610 >> 1);
    bus_astb_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      bus_addr = (i % 2 == 1) ? 31'(32'h12345614 >> 1) : 31'(32'h12345610 >> 1);
    end
    repeat (2) @(negedge clk);
    bus_dstb_n = 2'b00;
    finish_cycle(2'd1, 1'b1, 32'h0, "R10 settled write");
    run_cycle('{6'h0D, 32'h12345614, 1'b1, 1'b0, 2'b00, 1'b0, 32'h0, 1'b0, 2'd1, 32'h55AA55AA}, "R10 settled word");
    run_cycle('{6'h0D, 32'h12345610, 1'b1, 1'b0, 2'b00, 1'b0, 32'h0, 1'b0, 2'd1, 32'h00000000}, "R10 other word");

    // R1: reset in the middle of an answered read clears everything.
    @(negedge clk);
    bus_amod   = 6'h0D;
    bus_addr   = 31'(32'h12345600 >> 1);
    bus_wr_n   = 1'b1;
    bus_long_n = 1'b0;
    @(negedge clk);
    bus_astb_n = 1'b0;
    repeat (2) @(negedge clk);
    bus_dstb_n = 2'b00;
    for (int i = 0; i < 16 && bus_ack_n; i++) @(negedge clk);
    chk(!bus_ack_n, "R1 setup ack", 32'(bus_ack_n), 32'd0);
    rst_n      = 1'b0;
    bus_astb_n = 1'b1;
    bus_dstb_n = 2'b11;
    @(negedge clk);
    chk(answer() == 2'd0 && !bus_dout_en, "R1 mid-cycle reset", 32'(answer()), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_cycle('{6'h0D, 32'h12345600, 1'b1, 1'b0, 2'b00, 1'b0, 32'h0, 1'b0, 2'd1, 32'h00000000}, "R1 array cleared");

    summary();
    $finish;
  end

endmodule